// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block sits between the bit-level receiver of a CAN controller and its receive FIFO. It decides whether a frame that has just arrived should be kept. Software programs a bank of identifier-code and identifier-mask pairs through a small write port. Each mask marks which identifier bits matter. When the receiver raises its frame-valid strobe, the block compares the frame's identifier with every pair in parallel. Exactly one clock later it reports an accept or reject verdict and the number of the filter that matched.

Both identifier lengths are handled. An extended frame is compared over all 29 bits. A standard frame is compared over its low 11 bits only, and anything the receiver leaves in the upper bits is ignored. After reset every pair lets every frame through. The filters can only be rewritten while the controller is out of its running state. While running, writes are dropped, so the stored values cannot change under live traffic.

Top module: `canflt_top`

## Requirements
- R1: After reset every pair holds code 0 and mask 0x1FFFFFFF (all don't care), so any frame, standard or extended, is accepted and reported as filter 0.
- R2: An extended frame (frame format flag = 1) matches a pair when ((id XOR code) AND NOT mask) is zero over all 29 bits; a mask bit of 1 makes that identifier bit irrelevant.
- R3: A standard frame (frame format flag = 0) is compared on identifier, code and mask bits 10..0 only; bits 28..11 of all three are treated as don't care.
- R4: When several pairs match, the reported index is the lowest-numbered matching pair.
- R5: When no pair matches, the verdict is reject and the reported index is 0.
- R6: The result strobe is high in exactly the cycle after each frame-valid cycle, back-to-back frames included. In every cycle without the strobe, the accept and index outputs are 0.
- R7: Filter writes made while the run-mode input is 1 are ignored, and the stored values are kept.
- R8: Write address 2k selects the code of pair k and address 2k+1 selects its mask, for k = 0..5. Writes to addresses 12 to 15 change nothing.
- R9: A write and a frame-valid strobe in the same cycle: the frame is judged with the filter values from before the write, and the next frame sees the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_mode | input | 1 | Controller running; 1 locks the filter bank |
| cfg_wr_en | input | 1 | Filter register write strobe |
| cfg_addr | input | 4 | Filter register address (pair*2 + 0 code / 1 mask) |
| cfg_wdata | input | 29 | Filter register write data |
| frm_valid | input | 1 | One-cycle strobe: identifier inputs are valid |
| frm_ext | input | 1 | Frame format: 1 extended, 0 standard |
| frm_id | input | 29 | Received identifier |
| res_valid | output | 1 | Verdict strobe, one cycle after frm_valid |
| res_accept | output | 1 | 1 when at least one pair matched |
| res_index | output | 3 | Lowest matching pair number |

## Verification
A register write and a frame compare can land in the same clock edge. This can happen when the filter bank is reprogrammed in reset mode while the receiver still delivers a frame. The bench provokes this by raising a code write for pair 4 and a strobe for an identifier that matches only the old code in the same cycle. The verdict must be accept on filter 4, since it was judged with the old contents. The next two frames must show the new code in effect: the old identifier is now rejected and the new one is accepted.

// File: rtl/canflt_pkg.sv
package canflt_pkg;

    // Default sizing of the filter bank
    localparam int CF_ID_W     = 29;
    localparam int CF_STD_W    = 11;
    localparam int CF_NUM_FILT = 6;

    // Low address bit selects which half of a pair is written
    typedef enum logic {
        REG_CODE = 1'b0,
        REG_MASK = 1'b1
    } reg_kind_e;

endpackage

// File: rtl/canflt_regbank.sv
module canflt_regbank
    import canflt_pkg::*;
#(
    parameter int NUM_FILT = CF_NUM_FILT,
    parameter int ID_W     = CF_ID_W,
    parameter int ADDR_W   = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           lock,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [ID_W-1:0]                wr_data,
    output logic [NUM_FILT-1:0][ID_W-1:0]  code_o,
    output logic [NUM_FILT-1:0][ID_W-1:0]  mask_o
);

    localparam int SLOT_W = ADDR_W - 1;
    localparam logic [ID_W-1:0] ALL_DC = '1;

    logic              wr_ok;
    reg_kind_e         kind;
    logic [SLOT_W-1:0] slot;

    assign wr_ok = wr_en && !lock;
    assign kind  = reg_kind_e'(wr_addr[0]);
    assign slot  = wr_addr[ADDR_W-1:1];

    for (genvar k = 0; k < NUM_FILT; k++) begin : g_pair
        logic hit_slot;
        assign hit_slot = wr_ok && (slot == SLOT_W'(k));

        always_ff @(posedge clk) begin
            if (rst) begin
                code_o[k] <= '0;
                mask_o[k] <= ALL_DC;
            end else if (hit_slot) begin
                if (kind == REG_CODE) begin
                    code_o[k] <= wr_data;
                end else begin
                    mask_o[k] <= wr_data;
                end
            end
        end
    end

    // R7: a locked bank does not move
    assert_locked_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && lock) |=> ($stable(code_o) && $stable(mask_o)));

    // R8: addresses beyond the last pair touch nothing
    assert_unmapped_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !lock && (int'(slot) >= NUM_FILT)) |=> ($stable(code_o) && $stable(mask_o)));

endmodule

// File: rtl/canflt_match.sv
module canflt_match
    import canflt_pkg::*;
#(
    parameter int NUM_FILT = CF_NUM_FILT,
    parameter int ID_W     = CF_ID_W,
    parameter int STD_W    = CF_STD_W
) (
    input  logic                           frm_ext,
    input  logic [ID_W-1:0]                frm_id,
    input  logic [NUM_FILT-1:0][ID_W-1:0]  code_i,
    input  logic [NUM_FILT-1:0][ID_W-1:0]  mask_i,
    output logic [NUM_FILT-1:0]            hit_o
);

    // Bits that take part in the compare for each frame format
    localparam logic [ID_W-1:0] STD_SPAN = {{(ID_W-STD_W){1'b0}}, {STD_W{1'b1}}};
    localparam logic [ID_W-1:0] EXT_SPAN = '1;

    logic [ID_W-1:0] span;
    assign span = frm_ext ? EXT_SPAN : STD_SPAN;

    for (genvar k = 0; k < NUM_FILT; k++) begin : g_cmp
        logic [ID_W-1:0] diff;
        assign diff     = (frm_id ^ code_i[k]) & ~mask_i[k] & span;
        assign hit_o[k] = ~|diff;
    end

endmodule

// File: rtl/canflt_prio.sv
module canflt_prio
    import canflt_pkg::*;
#(
    parameter int NUM_FILT = CF_NUM_FILT,
    parameter int IDX_W    = $clog2(CF_NUM_FILT)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_FILT-1:0] hit_i,
    output logic                any_o,
    output logic [IDX_W-1:0]    idx_o
);

    // Scan from the top so that the lowest set hit wins
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int k = NUM_FILT - 1; k >= 0; k--) begin
            if (hit_i[k]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(k);
            end
        end
    end

    // R4: the reported pair matched and no lower pair did
    assert_lowest_R4: assert property (@(posedge clk) disable iff (rst)
        any_o |-> ((((hit_i >> idx_o) & NUM_FILT'(1)) != '0) &&
                   ((hit_i & ((NUM_FILT'(1) << idx_o) - NUM_FILT'(1))) == '0)));

    // R5: nothing matched means reject with index 0
    assert_nomatch_R5: assert property (@(posedge clk) disable iff (rst)
        (hit_i == '0) |-> (!any_o && idx_o == '0));

endmodule

// File: rtl/canflt_top.sv
module canflt_top
    import canflt_pkg::*;
#(
    parameter int NUM_FILT = CF_NUM_FILT,
    parameter int ID_W     = CF_ID_W,
    parameter int STD_W    = CF_STD_W,
    parameter int ADDR_W   = $clog2(2 * CF_NUM_FILT),
    parameter int IDX_W    = $clog2(CF_NUM_FILT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_mode,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [ID_W-1:0]   cfg_wdata,
    input  logic              frm_valid,
    input  logic              frm_ext,
    input  logic [ID_W-1:0]   frm_id,
    output logic              res_valid,
    output logic              res_accept,
    output logic [IDX_W-1:0]  res_index
);

    logic [NUM_FILT-1:0][ID_W-1:0] code_q;
    logic [NUM_FILT-1:0][ID_W-1:0] mask_q;
    logic [NUM_FILT-1:0]           hit;
    logic                          any_hit;
    logic [IDX_W-1:0]              hit_idx;

    canflt_regbank #(
        .NUM_FILT (NUM_FILT),
        .ID_W     (ID_W),
        .ADDR_W   (ADDR_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .lock    (run_mode),
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .code_o  (code_q),
        .mask_o  (mask_q)
    );

    canflt_match #(
        .NUM_FILT (NUM_FILT),
        .ID_W     (ID_W),
        .STD_W    (STD_W)
    ) u_match (
        .frm_ext (frm_ext),
        .frm_id  (frm_id),
        .code_i  (code_q),
        .mask_i  (mask_q),
        .hit_o   (hit)
    );

    canflt_prio #(
        .NUM_FILT (NUM_FILT),
        .IDX_W    (IDX_W)
    ) u_prio (
        .clk   (clk),
        .rst   (rst),
        .hit_i (hit),
        .any_o (any_hit),
        .idx_o (hit_idx)
    );

    // Verdict register: one cycle after the strobe, zero otherwise
    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_accept <= 1'b0;
            res_index  <= '0;
        end else begin
            res_valid  <= frm_valid;
            res_accept <= frm_valid && any_hit;
            res_index  <= (frm_valid && any_hit) ? hit_idx : '0;
        end
    end

    // R6: strobe follows every frame-valid cycle and only those
    assert_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        frm_valid |=> res_valid);

    assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> !res_valid);

    assert_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (!res_accept && res_index == '0));

    // R4: reported index always names an existing pair
    assert_index_range_R4: assert property (@(posedge clk) disable iff (rst)
        res_accept |-> (int'(res_index) < NUM_FILT));

endmodule

// File: tb/sim_canflt_top.sv
`timescale 1ns/1ps
module sim_canflt_top;

    typedef struct packed {
        logic        ext;
        logic [28:0] id;
        logic        acc;
        logic [2:0]  idx;
    } vec_t;

    // Filter programming used by the table walk
    localparam logic [28:0] PCODE [6] = '{29'h00000123, 29'h1FFF0000, 29'h1F000555,
                                          29'h1FF00000, 29'h0AAAAAAA, 29'h00000700};
    localparam logic [28:0] PMASK [6] = '{29'h00000000, 29'h0000F800, 29'h00000000,
                                          29'h000FF800, 29'h00000000, 29'h000000FF};

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 29'h00000123, 1'b1, 3'd0},
        '{1'b0, 29'h00000123, 1'b1, 3'd0},
        '{1'b1, 29'h1FFF5000, 1'b1, 3'd1},
        '{1'b1, 29'h1FF3A800, 1'b1, 3'd3},
        '{1'b1, 29'h1FFF0000, 1'b1, 3'd1},
        '{1'b0, 29'h00000555, 1'b1, 3'd2},
        '{1'b1, 29'h00000555, 1'b0, 3'd0},
        '{1'b1, 29'h0AAAAAAA, 1'b1, 3'd4},
        '{1'b0, 29'h000007A5, 1'b1, 3'd5},
        '{1'b1, 29'h000007A5, 1'b1, 3'd5},
        '{1'b0, 29'h00000000, 1'b1, 3'd1},
        '{1'b1, 29'h10000000, 1'b0, 3'd0},
        '{1'b0, 29'h1F000555, 1'b1, 3'd2}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        run_mode;
    logic        cfg_wr_en;
    logic [3:0]  cfg_addr;
    logic [28:0] cfg_wdata;
    logic        frm_valid;
    logic        frm_ext;
    logic [28:0] frm_id;
    logic        res_valid;
    logic        res_accept;
    logic [2:0]  res_index;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    canflt_top u0 (
        .clk        (clk),
        .rst        (rst),
        .run_mode   (run_mode),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .frm_valid  (frm_valid),
        .frm_ext    (frm_ext),
        .frm_id     (frm_id),
        .res_valid  (res_valid),
        .res_accept (res_accept),
        .res_index  (res_index)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [28:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // Strobe one frame and check the verdict in the following cycle
    task automatic frame(input string req, input logic ext, input logic [28:0] id,
                         input logic acc, input logic [2:0] idx);
        @(negedge clk);
        frm_valid = 1'b1;
        frm_ext   = ext;
        frm_id    = id;
        @(negedge clk);
        frm_valid = 1'b0;
        chk({req, " strobe"}, 32'(res_valid), 32'd1);
        chk({req, " accept"}, 32'(res_accept), 32'(acc));
        chk({req, " index"},  32'(res_index),  32'(idx));
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; run_mode = 1'b0; cfg_wr_en = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        frm_valid = 1'b0; frm_ext = 1'b0; frm_id = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R6: idle outputs after reset
        chk("R6 idle strobe", 32'(res_valid), 32'd0);
        chk("R6 idle accept", 32'(res_accept), 32'd0);

        // R1: default bank accepts everything on filter 0
        frame("R1 ext", 1'b1, 29'h1ABCDEF0, 1'b1, 3'd0);
        frame("R1 std", 1'b0, 29'h000007FF, 1'b1, 3'd0);

        // R8: program pairs through code at 2k, mask at 2k+1
        for (int k = 0; k < 6; k++) begin
            wr(4'(2 * k), PCODE[k]);
            wr(4'(2 * k + 1), PMASK[k]);
        end

        // R2 R3 R4 R5: table walk
        for (int v = 0; v < NVEC; v++) begin
            frame($sformatf("R2/R3/R4/R5 vec%0d", v), VECS[v].ext, VECS[v].id,
                  VECS[v].acc, VECS[v].idx);
        end

        // R6: back-to-back frames and idle after them
        @(negedge clk);
        frm_valid = 1'b1; frm_ext = 1'b1; frm_id = 29'h0AAAAAAA;
        @(negedge clk);
        frm_ext = 1'b0; frm_id = 29'h000007A5;
        chk("R6 b2b first accept", 32'(res_accept), 32'd1);
        chk("R6 b2b first index",  32'(res_index),  32'd4);
        @(negedge clk);
        frm_valid = 1'b0;
        chk("R6 b2b second strobe", 32'(res_valid), 32'd1);
        chk("R6 b2b second index",  32'(res_index), 32'd5);
        @(negedge clk);
        chk("R6 gap strobe", 32'(res_valid), 32'd0);
        chk("R6 gap index",  32'(res_index), 32'd0);

        // R7: writes while running are dropped
        run_mode = 1'b1;
        wr(4'd0, 29'h1FFFFFFF);
        wr(4'd1, 29'h1FFFFFFF);
        frame("R7 locked code", 1'b1, 29'h00000123, 1'b1, 3'd0);
        frame("R7 locked mask", 1'b1, 29'h00000124, 1'b0, 3'd0);
        run_mode = 1'b0;

        // R8: unmapped addresses change nothing
        wr(4'd12, 29'h1FFFFFFF);
        wr(4'd13, 29'h1FFFFFFF);
        wr(4'd15, 29'h00000000);
        frame("R8 unmapped", 1'b1, 29'h10000000, 1'b0, 3'd0);
        frame("R8 unmapped keep", 1'b1, 29'h00000123, 1'b1, 3'd0);

        // R9: write and frame in the same cycle
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = 4'd8; cfg_wdata = 29'h0BBBBBBB;
        frm_valid = 1'b1; frm_ext = 1'b1; frm_id = 29'h0AAAAAAA;
        @(negedge clk);
        cfg_wr_en = 1'b0; frm_valid = 1'b0;
        chk("R9 same-cycle accept", 32'(res_accept), 32'd1);
        chk("R9 same-cycle index",  32'(res_index),  32'd4);
        frame("R9 old code gone", 1'b1, 29'h0AAAAAAA, 1'b0, 3'd0);
        frame("R9 new code live", 1'b1, 29'h0BBBBBBB, 1'b1, 3'd4);

        // R1: reset restores the accept-all bank
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        frame("R1 after rereset", 1'b1, 29'h10000000, 1'b1, 3'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule